// File: doc/BRIEF.md
# Primary and Secondary Serial Frame Sequencer

This block times the transmit side of a 16-bit serial converter link. Every time the conversion-period strobe fires, it opens a primary frame: the active-low transmit frame sync falls for sixteen shift clocks, the bit-shift enable is high and a bit index walks from the most significant bit down to bit 0. If the secondary request flag is set when the last primary bit is shifted, the sequencer waits a fixed four shift clocks with frame sync high. It then runs a secondary control frame with the same bit timing, marked by a word-type tag. The secondary frame always sits between two primary frames, so the sample cadence is kept.

A period strobe that arrives while any frame or gap is in progress is held rather than dropped. The next primary frame then starts in the cycle right after the current frame ends. The receive frame sync has two modes. In synchronous mode it follows the transmit frame sync for primary frames only and stays high during secondary frames. In asynchronous mode it is timed by its own receive strobe, with no link to transmit activity. What the secondary word means is decoded elsewhere.

Top module: `fseq_top`

## Requirements
- R1: After reset, fsx_n and fsr_n are 1, and shift_en and word_sec are 0.
- R2: A period_stb seen at a clock edge while idle drives fsx_n low from that edge for exactly 16 cycles. During those cycles shift_en is 1 and word_sec is 0 (0 means primary).
- R3: During every frame, bit_idx is 15 in the first cycle and drops by one each cycle to 0 in the last cycle, so the most significant bit goes first.
- R4: If sec_req is 1 at the edge that ends the last primary bit, fsx_n stays high and shift_en low for exactly 4 cycles. Then a 16-cycle secondary frame follows with fsx_n low, shift_en 1 and word_sec 1.
- R5: If sec_req is 0 at that edge, no gap and no secondary frame follow, and the block returns to idle with fsx_n high.
- R6: With sync_mode=1, fsr_n is low exactly in the cycles of a primary frame and stays high during the gap and the secondary frame. rx_period_stb has no effect in this mode.
- R7: A period_stb that arrives during a primary frame, a gap or a secondary frame is held. The next primary frame begins in the cycle right after the current frame's last bit, with no idle cycle between.
- R8: With sync_mode=0, an rx_period_stb seen while no receive frame is active drives fsr_n low for exactly 16 cycles, whatever the transmit side is doing, including during a secondary frame.
- R9: With sync_mode=0, an rx_period_stb that arrives during an active receive frame is ignored. The frame still ends 16 cycles after its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1: receive sync follows primary frames; 0: receive sync is independent |
| period_stb | input | 1 | Conversion-period strobe, one cycle |
| rx_period_stb | input | 1 | Receive-period strobe used in asynchronous mode |
| sec_req | input | 1 | Secondary frame request, sampled at the last primary bit |
| fsx_n | output | 1 | Transmit frame sync, active low |
| fsr_n | output | 1 | Receive frame sync, active low |
| shift_en | output | 1 | Bit-shift enable, high during frame bits |
| word_sec | output | 1 | Word-type tag: 0 primary, 1 secondary |
| bit_idx | output | 4 | Index of the bit being shifted, 15 down to 0 |

## Verification
The main function is run as a table of single transfers covering all four combinations of sync_mode and sec_req. This separates the lone primary frame from the primary-gap-secondary sequence and shows whether the receive sync tracks the secondary frame. Directed runs then send a period strobe during a secondary frame and one during a plain primary frame. These show whether the strobe is held and the next primary starts with no idle cycle. Receive strobes are sent in asynchronous mode at the start of a gap, twice inside one receive frame, and in synchronous mode. These separate an independent receive timer from one tied to transmit activity.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRI  = 2'd1,
        ST_GAP  = 2'd2,
        ST_SEC  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/fseq_tx_ctrl.sv
module fseq_tx_ctrl
    import fseq_pkg::*;
#(
    parameter int WORD_BITS  = 16,
    parameter int GAP_CYCLES = 4,
    localparam int IDX_W     = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_stb,
    input  logic             sec_req,
    output logic             pri_active,
    output logic             sec_active,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int MAXC  = (WORD_BITS > GAP_CYCLES) ? WORD_BITS : GAP_CYCLES;
    localparam int CNT_W = $clog2(MAXC);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tx_regs_t;

    tx_regs_t r_q, r_d;
    logic     start_ok;

    always_comb begin
        r_d      = r_q;
        start_ok = period_stb | r_q.pend;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.cnt = '0;
                if (start_ok) begin
                    r_d.state = ST_PRI;
                    r_d.pend  = 1'b0;
                end
            end
            ST_PRI: begin
                if (r_q.cnt == LAST) begin
                    r_d.cnt = '0;
                    if (sec_req) begin
                        r_d.state = ST_GAP;
                        r_d.pend  = r_q.pend | period_stb;
                    end else if (start_ok) begin
                        r_d.state = ST_PRI;
                        r_d.pend  = 1'b0;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.pend  = 1'b0;
                    end
                end else begin
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.pend = r_q.pend | period_stb;
                end
            end
            ST_GAP: begin
                r_d.pend = r_q.pend | period_stb;
                if (r_q.cnt == GAP_LAST) begin
                    r_d.state = ST_SEC;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_SEC: begin
                if (r_q.cnt == LAST) begin
                    r_d.cnt  = '0;
                    r_d.pend = 1'b0;
                    r_d.state = start_ok ? ST_PRI : ST_IDLE;
                end else begin
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.pend = r_q.pend | period_stb;
                end
            end
            default: r_d = '{state: ST_IDLE, cnt: '0, pend: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, cnt: '0, pend: 1'b0};
        else        r_q <= r_d;
    end

    assign pri_active = (r_q.state == ST_PRI);
    assign sec_active = (r_q.state == ST_SEC);
    assign bit_idx    = IDX_W'(LAST - r_q.cnt);

    // R2 / R3: a frame advances one bit per cycle without leaving its state
    a_r3_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_PRI || r_q.state == ST_SEC) && r_q.cnt != LAST)
        |=> (r_q.state == $past(r_q.state) && r_q.cnt == CNT_W'($past(r_q.cnt) + 1'b1)));

    // R4: the gap always ends in a secondary frame
    a_r4_gap_to_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_GAP && r_q.cnt == GAP_LAST) |=> (r_q.state == ST_SEC));

    // R5: without a request the primary frame is not followed by a gap
    a_r5_no_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PRI && r_q.cnt == LAST && !sec_req)
        |=> (r_q.state != ST_GAP && r_q.state != ST_SEC));

    // R7: a strobe while busy is either held or has just started a primary frame
    a_r7_hold_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (period_stb && r_q.state != ST_IDLE)
        |=> (r_q.pend || (r_q.state == ST_PRI && r_q.cnt == '0)));
endmodule

// File: rtl/fseq_rx_frame.sv
module fseq_rx_frame #(
    parameter int WORD_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rx_stb,
    output logic active
);
    localparam int CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } rx_regs_t;

    rx_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!enable) begin
            r_d.active = 1'b0;
            r_d.cnt    = '0;
        end else if (r_q.active) begin
            if (r_q.cnt == LAST) begin
                r_d.active = 1'b0;
                r_d.cnt    = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else if (rx_stb) begin
            r_d.active = 1'b1;
            r_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{active: 1'b0, cnt: '0};
        else        r_q <= r_d;
    end

    assign active = r_q.active;

    // R8 / R9: an active receive frame runs its full length regardless of strobes
    a_r9_rx_full_len: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.active && r_q.cnt != LAST && enable) |=> (r_q.active && r_q.cnt != '0));

    // R8: a receive frame starts only from a strobe
    a_r8_rx_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.active && !rx_stb) |=> !r_q.active);
endmodule

// File: rtl/fseq_top.sv
module fseq_top #(
    parameter int WORD_BITS  = 16,
    parameter int GAP_CYCLES = 4,
    localparam int IDX_W     = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode,
    input  logic             period_stb,
    input  logic             rx_period_stb,
    input  logic             sec_req,
    output logic             fsx_n,
    output logic             fsr_n,
    output logic             shift_en,
    output logic             word_sec,
    output logic [IDX_W-1:0] bit_idx
);
    logic pri_active;
    logic sec_active;
    logic rx_active;

    fseq_tx_ctrl #(
        .WORD_BITS  (WORD_BITS),
        .GAP_CYCLES (GAP_CYCLES)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_stb (period_stb),
        .sec_req    (sec_req),
        .pri_active (pri_active),
        .sec_active (sec_active),
        .bit_idx    (bit_idx)
    );

    fseq_rx_frame #(
        .WORD_BITS (WORD_BITS)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!sync_mode),
        .rx_stb (rx_period_stb),
        .active (rx_active)
    );

    assign shift_en = pri_active | sec_active;
    assign fsx_n    = !(pri_active | sec_active);
    assign word_sec = sec_active;
    assign fsr_n    = sync_mode ? !pri_active : !rx_active;
endmodule

// File: tb/fseq_top_bench.sv
module fseq_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic       period_stb = 1'b0;
    logic       rx_period_stb = 1'b0;
    logic       sec_req = 1'b0;
    logic       fsx_n, fsr_n, shift_en, word_sec;
    logic [3:0] bit_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fseq_top u_fseq_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_mode     (sync_mode),
        .period_stb    (period_stb),
        .rx_period_stb (rx_period_stb),
        .sec_req       (sec_req),
        .fsx_n         (fsx_n),
        .fsr_n         (fsr_n),
        .shift_en      (shift_en),
        .word_sec      (word_sec),
        .bit_idx       (bit_idx)
    );

    // vector: {sync_mode, sec_req, expected gap length}
    typedef struct packed {
        logic       sync;
        logic       sec;
        logic [3:0] gap;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{sync: 1'b0, sec: 1'b0, gap: 4'd0},
        '{sync: 1'b1, sec: 1'b0, gap: 4'd0},
        '{sync: 1'b1, sec: 1'b1, gap: 4'd4},
        '{sync: 1'b0, sec: 1'b1, gap: 4'd4}
    };

    task automatic expect_out(input string req, input logic e_fsx, input logic e_fsr,
                              input logic e_sh, input logic e_tag, input int e_idx);
        checks++;
        if ({fsx_n, fsr_n, shift_en, word_sec} !== {e_fsx, e_fsr, e_sh, e_tag}) begin
            errors++;
            $display("FAIL %s: {fsx_n,fsr_n,shift_en,word_sec} actual=%b expected=%b at %0t",
                     req, {fsx_n, fsr_n, shift_en, word_sec}, {e_fsx, e_fsr, e_sh, e_tag}, $time);
        end
        if (e_idx >= 0) begin
            checks++;
            if (bit_idx !== 4'(e_idx)) begin
                errors++;
                $display("FAIL R3: bit_idx actual=%0d expected=%0d at %0t", bit_idx, e_idx, $time);
            end
        end
    endtask

    task automatic tx_transfer(input logic sync, input logic sec, input int gap);
        sync_mode  = sync;
        sec_req    = sec;
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        for (int i = 0; i < 16; i++) begin
            expect_out("R2 primary", 1'b0, sync ? 1'b0 : 1'b1, 1'b1, 1'b0, 15 - i);
            @(negedge clk);
        end
        sec_req = 1'b0;
        for (int i = 0; i < gap; i++) begin
            expect_out("R4 gap", 1'b1, 1'b1, 1'b0, 1'b0, -1);
            @(negedge clk);
        end
        if (gap > 0) begin
            for (int i = 0; i < 16; i++) begin
                expect_out("R4/R6 secondary", 1'b0, 1'b1, 1'b1, 1'b1, 15 - i);
                @(negedge clk);
            end
        end
        expect_out("R5 idle after transfer", 1'b1, 1'b1, 1'b0, 1'b0, -1);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_out("R1 in reset", 1'b1, 1'b1, 1'b0, 1'b0, -1);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1'b1, 1'b1, 1'b0, 1'b0, -1);

        for (int v = 0; v < 4; v++) begin
            tx_transfer(VECS[v].sync, VECS[v].sec, int'(VECS[v].gap));
        end

        // R7: strobe during a secondary frame is held; primary follows at once
        sync_mode  = 1'b1;
        sec_req    = 1'b1;
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        for (int i = 0; i < 16; i++) @(negedge clk);
        sec_req = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            expect_out("R7 secondary before held strobe", 1'b0, 1'b1, 1'b1, 1'b1, 15 - i);
            period_stb = (i == 3);
            @(negedge clk);
        end
        period_stb = 1'b0;
        for (int i = 0; i < 16; i++) begin
            expect_out("R7 held primary", 1'b0, 1'b0, 1'b1, 1'b0, 15 - i);
            @(negedge clk);
        end
        expect_out("R7 idle after held primary", 1'b1, 1'b1, 1'b0, 1'b0, -1);

        // R7: strobe during a primary frame gives a back-to-back primary
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        for (int i = 0; i < 16; i++) begin
            period_stb = (i == 8);
            @(negedge clk);
        end
        period_stb = 1'b0;
        expect_out("R7 back-to-back primary first bit", 1'b0, 1'b0, 1'b1, 1'b0, 15);
        for (int i = 0; i < 16; i++) @(negedge clk);
        expect_out("R7 idle after back-to-back", 1'b1, 1'b1, 1'b0, 1'b0, -1);

        // R6: receive strobe has no effect in synchronous mode
        rx_period_stb = 1'b1;
        @(negedge clk);
        rx_period_stb = 1'b0;
        for (int i = 0; i < 3; i++) begin
            expect_out("R6 rx strobe ignored in sync mode", 1'b1, 1'b1, 1'b0, 1'b0, -1);
            @(negedge clk);
        end

        // R8: asynchronous receive frame runs during a secondary frame
        sync_mode  = 1'b0;
        @(negedge clk);
        sec_req    = 1'b1;
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        for (int i = 0; i < 16; i++) begin
            expect_out("R8 primary, no rx strobe", 1'b0, 1'b1, 1'b1, 1'b0, 15 - i);
            @(negedge clk);
        end
        sec_req       = 1'b0;
        rx_period_stb = 1'b1;   // gap cycle 0
        @(negedge clk);
        rx_period_stb = 1'b0;
        for (int i = 1; i < 4; i++) begin
            expect_out("R8 rx frame in gap", 1'b1, 1'b0, 1'b0, 1'b0, -1);
            @(negedge clk);
        end
        for (int i = 0; i < 16; i++) begin
            expect_out("R8 rx frame across secondary", 1'b0, (i < 13) ? 1'b0 : 1'b1,
                       1'b1, 1'b1, 15 - i);
            @(negedge clk);
        end

        // R9: second receive strobe inside an active receive frame is ignored
        repeat (2) @(negedge clk);
        rx_period_stb = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            rx_period_stb = (i == 5);
            expect_out("R9 rx frame", 1'b1, 1'b0, 1'b0, 1'b0, -1);
            @(negedge clk);
        end
        rx_period_stb = 1'b0;
        expect_out("R9 rx frame ends after 16", 1'b1, 1'b1, 1'b0, 1'b0, -1);
        @(negedge clk);
        expect_out("R9 no restart from ignored strobe", 1'b1, 1'b1, 1'b0, 1'b0, -1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule